// File: doc/BRIEF.md
# Toggle-Handshake Event Synchronizer

This block carries single events from a sender clock domain to an unrelated receiver clock domain. The two sides share one request line and one acknowledge line. The sender announces an event by flipping the request level. The receiver detects that its synchronized copy of the request no longer matches its own acknowledge. It then emits a one-cycle pulse and flips the acknowledge to match. The sender sees the acknowledge return through its own synchronizer and becomes free again.

The sender side is a valid/ready input. An event is taken on a sender clock edge where `ev_valid` and `ev_ready` are both high. While a handshake is in flight, `ev_ready` stays low. A held `ev_valid` then simply waits and is not queued. No data travels with the event, and a full round trip through both synchronizers is paid for every event. The block therefore suits occasional notifications and does not suit sustained streams.

Top module: `evx_toggle_sync`

## Requirements
- R1: After each side's synchronous reset, the request and acknowledge lines are 0, `ev_ready` is 1 and `ev_pulse` is 0.
- R2: An event is accepted on a rising `snd_clk` edge where `ev_valid` and `ev_ready` are both 1. In the following sender cycle `ev_ready` is 0.
- R3: `ev_valid` while `ev_ready` is 0 is ignored. The request line does not change and no extra receiver pulse results.
- R4: `ev_pulse` is high for exactly one `rcv_clk` cycle per event. It is never high in two consecutive receiver cycles.
- R5: Every accepted event yields exactly one receiver pulse, with none lost or duplicated, for any ratio of the two clock frequencies. Each pulse coincides with a flip of the acknowledge line.
- R6: The line levels carry no meaning. A request going 0 to 1 and a request going 1 to 0 both produce a pulse, so consecutive events alternate the line level.
- R7: The request is synchronized into the receiver domain, and the acknowledge into the sender domain, through at least two series flops (`SYNC_STAGES`, minimum 2). After an accept, `ev_ready` therefore stays low for at least two sender cycles and returns to 1 once the acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| snd_clk | input | 1 | Sender domain clock |
| snd_rst | input | 1 | Sender domain synchronous reset, active high |
| ev_valid | input | 1 | Sender requests an event |
| ev_ready | output | 1 | Channel idle; an event can be accepted this cycle |
| rcv_clk | input | 1 | Receiver domain clock |
| rcv_rst | input | 1 | Receiver domain synchronous reset, active high |
| ev_pulse | output | 1 | One-cycle event pulse in the receiver domain |

## Verification
The bench keeps the sender clock at 50 MHz and sweeps the receiver period through values that are equal to, faster than and slower than the sender, as well as near-equal. At each ratio it drives three valid patterns:
- A permanently held strobe. This tells a correct back-pressure from one that double-accepts or queues events.
- A sparse strobe. This shows that isolated events arrive singly.
- A pseudo-random strobe. This mixes both cases.

The bench counts accepted events against received pulses and measures how long the channel stays busy after each accept. A mismatch between the two counts exposes lost or duplicated events. A busy time that is too short exposes a shortened synchronizer.

// File: rtl/evx_pkg.sv
package evx_pkg;

  // Fewest flops allowed in any crossing chain.
  localparam int unsigned EVX_MIN_STAGES = 2;

  // Clamp a requested synchronizer depth to the allowed minimum.
  function automatic int unsigned evx_stages(input int unsigned requested);
    return (requested < EVX_MIN_STAGES) ? EVX_MIN_STAGES : requested;
  endfunction

  // Handshake state as seen by the sender.
  typedef enum logic {
    EVX_IDLE = 1'b0,
    EVX_BUSY = 1'b1
  } evx_chan_e;

endpackage

// File: rtl/evx_bit_sync.sv
module evx_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  import evx_pkg::*;

  localparam int unsigned DEPTH = evx_stages(STAGES);

  logic [DEPTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[DEPTH-1];
endmodule

// File: rtl/evx_send.sv
module evx_send #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  output logic ready,
  output logic req_out,
  input  logic ack_async
);
  import evx_pkg::*;

  logic      req_q;
  logic      ack_seen;
  evx_chan_e chan_state;
  logic      take;

  evx_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (ack_async),
    .q_sync  (ack_seen)
  );

  // Busy whenever the returned acknowledge lags the request.
  always_comb begin
    chan_state = (ack_seen == req_q) ? EVX_IDLE : EVX_BUSY;
    ready      = (chan_state == EVX_IDLE);
    take       = valid && ready;
  end

  always_ff @(posedge clk) begin
    if (rst)       req_q <= 1'b0;
    else if (take) req_q <= ~req_q;
  end

  assign req_out = req_q;
endmodule

// File: rtl/evx_recv.sv
module evx_recv #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic pulse,
  output logic ack_out
);
  logic req_seen;
  logic ack_q;
  logic pulse_q;
  logic pending;

  evx_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (req_async),
    .q_sync  (req_seen)
  );

  assign pending = req_seen ^ ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pending;
      if (pending) ack_q <= req_seen;
    end
  end

  assign pulse   = pulse_q;
  assign ack_out = ack_q;
endmodule

// File: rtl/evx_toggle_sync.sv
module evx_toggle_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic snd_clk,
  input  logic snd_rst,
  input  logic ev_valid,
  output logic ev_ready,
  input  logic rcv_clk,
  input  logic rcv_rst,
  output logic ev_pulse
);
  logic req_line;
  logic ack_line;

  evx_send #(.SYNC_STAGES(SYNC_STAGES)) u_send (
    .clk       (snd_clk),
    .rst       (snd_rst),
    .valid     (ev_valid),
    .ready     (ev_ready),
    .req_out   (req_line),
    .ack_async (ack_line)
  );

  evx_recv #(.SYNC_STAGES(SYNC_STAGES)) u_recv (
    .clk       (rcv_clk),
    .rst       (rcv_rst),
    .req_async (req_line),
    .pulse     (ev_pulse),
    .ack_out   (ack_line)
  );
endmodule

// File: rtl/evx_toggle_sync_chk.sv
module evx_toggle_sync_chk (
  input logic snd_clk,
  input logic snd_rst,
  input logic ev_valid,
  input logic ev_ready,
  input logic rcv_clk,
  input logic rcv_rst,
  input logic ev_pulse,
  input logic req_line,
  input logic ack_line
);

  assert_snd_reset_idle_R1: assert property (@(posedge snd_clk) disable iff (snd_rst)
    $past(snd_rst) |-> (ev_ready && !req_line));

  assert_rcv_reset_quiet_R1: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
    $past(rcv_rst) |-> (!ev_pulse && !ack_line));

  assert_accept_goes_busy_R2: assert property (@(posedge snd_clk) disable iff (snd_rst)
    (ev_valid && ev_ready) |=> !ev_ready);

  assert_busy_strobe_ignored_R3: assert property (@(posedge snd_clk) disable iff (snd_rst)
    (ev_valid && !ev_ready) |=> $stable(req_line));

  assert_idle_no_toggle_R3: assert property (@(posedge snd_clk) disable iff (snd_rst)
    !ev_valid |=> $stable(req_line));

  assert_pulse_one_cycle_R4: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
    ev_pulse |=> !ev_pulse);

  assert_pulse_with_ack_flip_R5: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
    ev_pulse |-> (ack_line != $past(ack_line)));

endmodule

bind evx_toggle_sync evx_toggle_sync_chk u_chk (
  .snd_clk  (snd_clk),
  .snd_rst  (snd_rst),
  .ev_valid (ev_valid),
  .ev_ready (ev_ready),
  .rcv_clk  (rcv_clk),
  .rcv_rst  (rcv_rst),
  .ev_pulse (ev_pulse),
  .req_line (req_line),
  .ack_line (ack_line)
);

// File: tb/evx_toggle_sync_tb.sv
`timescale 1ns/1ps
module evx_toggle_sync_tb;
  localparam int unsigned STAGES = 2;

  logic snd_clk = 1'b0;
  logic rcv_clk = 1'b0;
  logic snd_rst = 1'b1;
  logic rcv_rst = 1'b1;
  logic ev_valid = 1'b0;
  logic ev_ready;
  logic ev_pulse;

  int snd_half = 10;   // 50 MHz sender clock
  int rcv_half = 10;

  int checks = 0;
  int fails  = 0;
  int accepts = 0;
  int pulses  = 0;
  int odd_pulses = 0;
  int even_pulses = 0;
  bit prev_pulse = 1'b0;
  bit done = 1'b0;

  always #(snd_half) snd_clk = ~snd_clk;
  always #(rcv_half) rcv_clk = ~rcv_clk;

  evx_toggle_sync #(.SYNC_STAGES(STAGES)) u_dut (
    .snd_clk  (snd_clk),
    .snd_rst  (snd_rst),
    .ev_valid (ev_valid),
    .ev_ready (ev_ready),
    .rcv_clk  (rcv_clk),
    .rcv_rst  (rcv_rst),
    .ev_pulse (ev_pulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Receiver monitor: pulse count and width (R4, R5, R6)
  always @(negedge rcv_clk) begin
    if (!rcv_rst) begin
      if (ev_pulse) begin
        pulses++;
        if (pulses % 2 == 1) odd_pulses++; else even_pulses++;
        check(!prev_pulse, "R4 pulse width", 2, 1);
      end
      prev_pulse = ev_pulse;
    end
  end

  task automatic run_phase(input int rhalf, input int mode, input int ncyc);
    int base_acc;
    int base_pls;
    int busy_strobes;
    bit tracking;
    int busy_len;
    bit last_take;
    rcv_half = rhalf;
    base_acc = accepts;
    base_pls = pulses;
    busy_strobes = 0;
    tracking = 1'b0;
    busy_len = 0;
    last_take = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      bit r;
      bit v;
      @(negedge snd_clk);
      r = ev_ready;
      if (last_take) begin
        check(!r, "R2 ready after accept", int'(r), 0);
        tracking = 1'b1;
        busy_len = 0;
      end
      if (tracking) begin
        if (!r) busy_len++;
        else begin
          check(busy_len >= STAGES, "R7 busy length", busy_len, STAGES);
          tracking = 1'b0;
        end
      end
      case (mode)
        0: v = 1'b1;
        1: v = (c % 37 == 0);
        default: v = 1'($urandom_range(0, 1));
      endcase
      ev_valid = v;
      last_take = v && r;
      if (last_take) accepts++;
      if (v && !r) busy_strobes++;
    end
    @(negedge snd_clk);
    ev_valid = 1'b0;
    repeat (300) @(negedge snd_clk);
    // R3 / R5: strobes while busy are dropped, every accept gives one pulse
    check((pulses - base_pls) == (accepts - base_acc), "R5 pulse count vs accepts",
          pulses - base_pls, accepts - base_acc);
    if (mode == 0)
      check(busy_strobes > 0 && (pulses - base_pls) < ncyc, "R3 busy strobes ignored",
            pulses - base_pls, accepts - base_acc);
    check(ev_ready == 1'b1, "R7 ready returns", int'(ev_ready), 1);
  endtask

  initial begin
    repeat (5) @(negedge snd_clk);
    snd_rst = 1'b0;
    rcv_rst = 1'b0;
    @(negedge snd_clk);
    check(ev_ready == 1'b1, "R1 ready after reset", int'(ev_ready), 1);
    check(ev_pulse == 1'b0, "R1 pulse after reset", int'(ev_pulse), 0);
    // receiver equal, faster, slower, near-equal
    for (int p = 0; p < 4; p++) begin
      int rh;
      case (p)
        0: rh = 10;
        1: rh = 4;
        2: rh = 27;
        default: rh = 13;
      endcase
      for (int m = 0; m < 3; m++) run_phase(rh, m, 500);
    end
    check(pulses == accepts, "R5 total pulses", pulses, accepts);
    // R6: both request directions produced pulses
    check(odd_pulses > 0 && even_pulses > 0, "R6 both levels", odd_pulses, even_pulses);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge snd_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule